// File: doc/BRIEF.md
# Paged Program Counter Unit

This block produces the 13-bit instruction fetch address of a small accumulator-style core. Each clock cycle the decoder presents one control code for the instruction that completes in that cycle: hold, step to the next word, take an 11-bit absolute jump or call, return through a hardware return-address stack, or overwrite the low address byte from the data path. A separate interrupt-entry strobe may accompany any of these codes.

The upper five address bits are never loaded directly. A five-bit high latch, written from the data bus, supplies them. A low-byte write takes all five latch bits. A jump or call takes only the top two, because the 11-bit target already covers the rest. Software therefore sees 2K-word pages for jumps and calls, and 256-word windows for computed jumps. The low byte of the counter can be read back on the data path. The upper bits cannot. Return-stack entries hold all 13 bits, so a return does not depend on the latch. Interrupt entry saves only the return address.

The block has no streaming data flow. Every pin is a plain level, sampled on each rising clock edge, with no valid/ready handshake and no back-pressure. The decoder must present `PC_HOLD` (code 0) in any cycle in which no instruction completes.

Top module: `paged_pc_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the fetch address is 0x0000. Reset also clears the high latch, so a low-byte write of D issued before any latch write gives address 0x00D (the upper five bits are zero).
- R2: Code 1 (`PC_INC`) advances the fetch address by one. The address wraps from 0x1FFF to 0x0000.
- R3: Code 0 (`PC_HOLD`) without interrupt entry leaves the fetch address unchanged.
- R4: Code 2 (`PC_JUMP`) loads {latch[4:3], imm[10:0]}. Latch bits 2:0 have no effect on the result.
- R5: Code 3 (`PC_CALL`) loads the same target as a jump and pushes the address of the call plus one. A later return resumes at that address.
- R6: Code 5 (`PC_LOWR`) loads {latch[4:0], wr_data[7:0]}. A latch write (`lat_we`, taking wr_data[4:0]) does not change the fetch address by itself.
- R7: `rd_pcl` always equals bits 7:0 of the current fetch address.
- R8: Code 4 (`PC_RET`) restores the full 13-bit address from the top of the stack. Changes made to the latch since the push have no effect.
- R9: The stack holds 8 entries and wraps around. After nine calls with no return between them, nine returns give the 9th, 8th, …, 2nd return addresses, and then the 9th again. No flag is raised.
- R10: Interrupt entry loads the vector 0x004 and pushes the address that would otherwise have been fetched next. With `PC_HOLD`, that is the current address.
- R11: When interrupt entry coincides with an instruction's control-flow event, the instruction completes first. With a call, the first return goes to the call target and the second to the call's successor. With a jump, the return goes to the jump target. With a return, the return goes to the popped address.
- R12: A low-byte write issued in the same cycle as a latch write uses the latch value held before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 3 | Control code: 0 hold, 1 step, 2 jump, 3 call, 4 return, 5 low-byte write |
| irq_entry | input | 1 | Interrupt entry in this cycle |
| imm | input | 11 | Absolute target field for jump and call |
| wr_data | input | 8 | Data-path write value for the low byte or the latch |
| lat_we | input | 1 | Write wr_data[4:0] into the high latch |
| rd_pcl | output | 8 | Read-back of the low address byte |
| fetch_addr | output | 13 | Current instruction fetch address |

## Verification
The bench uses the default parameters: a 13-bit address, an 11-bit target field, an 8-bit data byte, an 8-deep stack and vector 0x004. These values allow a nine-call chain that overruns the stack in a few dozen cycles. They also put the 0x1FFF wrap and both page boundaries within a single latch load. Every pairing of interrupt entry with a jump, call, return and hold is driven, and the bench follows the return chain after each one.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [2:0] {
    PC_HOLD = 3'd0,
    PC_INC  = 3'd1,
    PC_JUMP = 3'd2,
    PC_CALL = 3'd3,
    PC_RET  = 3'd4,
    PC_LOWR = 3'd5
  } pc_op_e;
endpackage

// File: rtl/pcu_hi_latch.sv
module pcu_hi_latch #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= din;
  end

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q)); // R6
endmodule

// File: rtl/pcu_next_addr.sv
module pcu_next_addr
  import pcu_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int IMM_W  = 11,
  parameter int BYTE_W = 8,
  parameter int VECTOR = 4
) (
  input  pc_op_e                     op,
  input  logic                       irq,
  input  logic [ADDR_W-1:0]          pc,
  input  logic [ADDR_W-BYTE_W-1:0]   lat,
  input  logic [IMM_W-1:0]           imm,
  input  logic [BYTE_W-1:0]          wdata,
  input  logic [ADDR_W-1:0]          stk_top,
  output logic [ADDR_W-1:0]          pc_d,
  output logic                       pop,
  output logic [1:0]                 push_n,
  output logic [ADDR_W-1:0]          push_w0,
  output logic [ADDR_W-1:0]          push_w1
);
  localparam int HI_W = ADDR_W - BYTE_W;
  localparam int PG_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] seq, far, nxt;
  logic              call;

  assign seq  = pc + ADDR_W'(1);
  assign far  = {lat[HI_W-1 -: PG_W], imm};
  assign call = (op == PC_CALL);

  always_comb begin
    case (op)
      PC_INC:           nxt = seq;
      PC_JUMP, PC_CALL: nxt = far;
      PC_RET:           nxt = stk_top;
      PC_LOWR:          nxt = {lat, wdata};
      default:          nxt = pc;
    endcase
  end

  // the interrupt is taken after the instruction completes: it stacks the successor
  assign pc_d    = irq ? ADDR_W'(VECTOR) : nxt;
  assign pop     = (op == PC_RET);
  assign push_n  = {1'b0, call} + {1'b0, irq};
  assign push_w0 = call ? seq : nxt;
  assign push_w1 = nxt;
endmodule

// File: rtl/pcu_ret_stack.sv
module pcu_ret_stack #(
  parameter int W     = 13,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pop,
  input  logic [1:0]   push_n,
  input  logic [W-1:0] w0,
  input  logic [W-1:0] w1,
  output logic [W-1:0] top
);
  // DEPTH is a power of two, so the pointer wraps on its own and overwrites the oldest entry
  localparam int PTR_W = $clog2(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] sp, base;

  assign base = pop ? sp - PTR_W'(1) : sp;
  assign top  = mem[sp - PTR_W'(1)];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push_n != 2'd0) mem[base] <= w0;
      if (push_n == 2'd2) mem[base + PTR_W'(1)] <= w1;
      sp <= base + PTR_W'(push_n);
    end
  end

  AST_STK_PUSH_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (push_n == 2'd1) |=> top == $past(w0)); // R5
  AST_STK_NO_POP_DOUBLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop && push_n == 2'd2)); // R11
  AST_STK_PAIR_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (push_n == 2'd2) |=> top == $past(w1)); // R11
endmodule

// File: rtl/paged_pc_unit.sv
module paged_pc_unit
  import pcu_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int IMM_W     = 11,
  parameter int BYTE_W    = 8,
  parameter int STK_DEPTH = 8,
  parameter int VECTOR    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op,
  input  logic              irq_entry,
  input  logic [IMM_W-1:0]  imm,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              lat_we,
  output logic [BYTE_W-1:0] rd_pcl,
  output logic [ADDR_W-1:0] fetch_addr
);
  localparam int HI_W = ADDR_W - BYTE_W;
  localparam int PG_W = ADDR_W - IMM_W;

  pc_op_e            op_e;
  logic [HI_W-1:0]   lat_q;
  logic [ADDR_W-1:0] pc_q, pc_d, stk_top, push_w0, push_w1;
  logic              pop;
  logic [1:0]        push_n;

  assign op_e = pc_op_e'(op);

  pcu_hi_latch #(.W(HI_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .we(lat_we), .din(wr_data[HI_W-1:0]), .q(lat_q)
  );

  pcu_next_addr #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .BYTE_W(BYTE_W), .VECTOR(VECTOR)) u_next (
    .op(op_e), .irq(irq_entry), .pc(pc_q), .lat(lat_q), .imm(imm), .wdata(wr_data),
    .stk_top(stk_top), .pc_d(pc_d), .pop(pop), .push_n(push_n),
    .push_w0(push_w0), .push_w1(push_w1)
  );

  pcu_ret_stack #(.W(ADDR_W), .DEPTH(STK_DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .pop(pop), .push_n(push_n),
    .w0(push_w0), .w1(push_w1), .top(stk_top)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign fetch_addr = pc_q;
  assign rd_pcl     = pc_q[BYTE_W-1:0];

  AST_VECTOR_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_entry |=> fetch_addr == ADDR_W'(VECTOR)); // R10
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_e == PC_HOLD && !irq_entry) |=> $stable(fetch_addr)); // R3
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_e == PC_INC && !irq_entry) |=> fetch_addr == $past(fetch_addr) + ADDR_W'(1)); // R2
  AST_JUMP_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_e == PC_JUMP && !irq_entry) |=>
      (fetch_addr[IMM_W-1:0] == $past(imm) &&
       fetch_addr[ADDR_W-1:IMM_W] == $past(lat_q[HI_W-1 -: PG_W]))); // R4
  AST_LOWR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (op_e == PC_LOWR && !irq_entry) |=>
      fetch_addr == {$past(lat_q), $past(wr_data)}); // R6
  AST_CALL_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (op_e == PC_CALL && !irq_entry) ##1 (op_e == PC_RET && !irq_entry) |=>
      fetch_addr == $past(fetch_addr, 2) + ADDR_W'(1)); // R5
endmodule

// File: tb/tb_paged_pc_unit.sv
module tb_paged_pc_unit;
  import pcu_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = 3'd0;
  logic        irq_entry = 1'b0;
  logic [10:0] imm = '0;
  logic [7:0]  wr_data = '0;
  logic        lat_we = 1'b0;
  logic [7:0]  rd_pcl;
  logic [12:0] fetch_addr;

  always #2 clk = ~clk;  // 250 MHz

  paged_pc_unit dut (
    .clk(clk), .rst_n(rst_n), .op(op), .irq_entry(irq_entry), .imm(imm),
    .wr_data(wr_data), .lat_we(lat_we), .rd_pcl(rd_pcl), .fetch_addr(fetch_addr)
  );

  typedef struct { logic [12:0] addr; string tag; } exp_t;
  exp_t sb[$];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model, built from the requirements
  logic [12:0] m_pc = '0;
  logic [4:0]  m_lat = '0;
  logic [12:0] m_stk [8];
  int          m_sp = 0;

  task automatic check(input bit ok, input string tag, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic m_push(input logic [12:0] v);
    m_stk[m_sp] = v;
    m_sp = (m_sp + 1) % 8;
  endtask

  task automatic step(input logic [2:0] o, input logic irq, input logic [10:0] im,
                      input logic [7:0] d, input logic lw, input string tag);
    logic [12:0] nx;
    exp_t e;
    @(negedge clk);
    op = o; irq_entry = irq; imm = im; wr_data = d; lat_we = lw;
    case (o)
      PC_INC:           nx = m_pc + 13'd1;
      PC_JUMP, PC_CALL: nx = {m_lat[4:3], im};
      PC_RET: begin
        m_sp = (m_sp + 7) % 8;
        nx = m_stk[m_sp];
      end
      PC_LOWR:          nx = {m_lat, d};
      default:          nx = m_pc;
    endcase
    if (o == PC_CALL) m_push(m_pc + 13'd1);
    if (irq) m_push(nx);
    m_pc = irq ? 13'h004 : nx;
    if (lw) m_lat = d[4:0];
    @(posedge clk);
    e.addr = m_pc; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(fetch_addr == e.addr, e.tag, fetch_addr, e.addr);
        check(rd_pcl == e.addr[7:0], {e.tag, " R7 rd_pcl"}, {5'd0, rd_pcl}, {5'd0, e.addr[7:0]});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m_stk[i] = '0;
    repeat (3) @(negedge clk);
    check(fetch_addr == 13'h0, "R1 in reset", fetch_addr, 13'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(fetch_addr == 13'h0, "R1 after reset", fetch_addr, 13'h0);

    // R2 step
    step(PC_INC, 0, 0, 0, 0, "R2 step");
    step(PC_INC, 0, 0, 0, 0, "R2 step");
    step(PC_INC, 0, 0, 0, 0, "R2 step");
    // R1 latch cleared at reset
    step(PC_LOWR, 0, 0, 8'h5A, 0, "R1 latch clear via low write");
    // R3 hold
    step(PC_HOLD, 0, 0, 0, 0, "R3 hold");
    step(PC_HOLD, 0, 0, 0, 0, "R3 hold");
    // R6 latch write alone does not move the address
    step(PC_HOLD, 0, 0, 8'h1F, 1, "R6 latch write no move");
    // R4 jumps
    step(PC_JUMP, 0, 11'h123, 0, 0, "R4 jump page 3");
    step(PC_HOLD, 0, 0, 8'h0B, 1, "R6 latch write no move");
    step(PC_JUMP, 0, 11'h7FF, 0, 0, "R4 jump low latch bits ignored");
    // R6 low-byte write with full latch
    step(PC_LOWR, 0, 0, 8'h34, 0, "R6 low write");
    // R5 call, R8 return after latch change
    step(PC_CALL, 0, 11'h200, 0, 0, "R5 call target");
    step(PC_HOLD, 0, 0, 8'h10, 1, "R6 latch write no move");
    step(PC_RET, 0, 0, 0, 0, "R8 full return");
    // R12 simultaneous latch and low write
    step(PC_LOWR, 0, 0, 8'h07, 1, "R12 old latch used");
    step(PC_LOWR, 0, 0, 8'h99, 0, "R12 new latch next");
    // R2 wrap
    step(PC_HOLD, 0, 0, 8'h1F, 1, "R6 latch write no move");
    step(PC_LOWR, 0, 0, 8'hFF, 0, "R6 low write top");
    step(PC_INC, 0, 0, 0, 0, "R2 wrap");
    // R9 stack overrun
    step(PC_HOLD, 0, 0, 8'h08, 1, "R6 latch write no move");
    for (int k = 0; k < 9; k++) step(PC_CALL, 0, 11'(16 * k + 3), 0, 0, "R9 call chain");
    for (int k = 0; k < 9; k++) step(PC_RET, 0, 0, 0, 0, "R9 return chain");
    // R10 interrupt with step
    step(PC_INC, 1, 0, 0, 0, "R10 vector");
    step(PC_INC, 0, 0, 0, 0, "R10 in handler");
    step(PC_RET, 0, 0, 0, 0, "R10 resume");
    // R10 interrupt with hold
    step(PC_HOLD, 1, 0, 0, 0, "R10 vector from hold");
    step(PC_RET, 0, 0, 0, 0, "R10 resume hold");
    // R11 interrupt with call
    step(PC_CALL, 1, 11'h155, 0, 0, "R11 call+irq vector");
    step(PC_RET, 0, 0, 0, 0, "R11 return to call target");
    step(PC_RET, 0, 0, 0, 0, "R11 return to call successor");
    // R11 interrupt with jump
    step(PC_JUMP, 1, 11'h0AA, 0, 0, "R11 jump+irq vector");
    step(PC_RET, 0, 0, 0, 0, "R11 return to jump target");
    // R11 interrupt with return
    step(PC_CALL, 0, 11'h321, 0, 0, "R5 call target");
    step(PC_RET, 1, 0, 0, 0, "R11 ret+irq vector");
    step(PC_RET, 0, 0, 0, 0, "R11 return to popped address");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule